// File: doc/BRIEF.md
# Host Report Register Access Controller

This block sits behind a host-side report transport and turns 4-byte command reports into accesses on two targets. The first target is a small bank of four 16-bit control registers. The second is a 64-word external serial memory, reached through a request/acknowledge port. Each command names its target with an opcode byte, carries a data word split into a low byte and a high byte, and ends with an address byte. Reads return data to the host in a 3-byte status report, which is offered with a valid/ready handshake. A microcontroller can also push a 16-bit word, and that word goes out in the same report format.

Byte 0 of every status report is a flag byte. One flag names the source of the data word: microcontroller, memory or register. The rest of the byte is live status. The volume-up and volume-down flags follow the debounced buttons for as long as they are held. The jack flag follows the synchronized jack-sense input. The mute flag is sticky: a press of the mute button sets it, and it clears once the host has taken a report. The button inputs are active-low raw pins. Each one is synchronized and then accepted only after `DB_CNT` consecutive equal samples.

A control sequencer with three states orders the work. `ST_IDLE` accepts commands. It goes to `ST_SEND` for a register read or for a pending microcontroller word, and to `ST_MEM_WAIT` for any in-range memory command. `ST_MEM_WAIT` holds the memory request until acknowledge. From there it returns to `ST_IDLE` after a write, or goes to `ST_SEND` after a read. `ST_SEND` holds the report until the host accepts it, then returns to `ST_IDLE`.

Top module: `host_report_regacc`

## Requirements
- R1: After reset, register 0 reads 0x0000, register 1 reads 0xB000, register 2 reads 0x0004, and register 3 reads 0x003E combined with its read-only status bits. No report is offered, no memory request is raised, and `cmd_ready` is 1.
- R2: Opcode 32 with an address byte of 0 to 3 writes {`cmd_hi`,`cmd_lo`} into that register. The new value shows on the register output one cycle after the command is accepted. The write produces no status report.
- R3: Opcode 48 with an address byte of 0 to 3 produces exactly one report. That report has flag bit 4 (register source) set, `rpt_lo`/`rpt_hi` equal to the register value, and bits 6 and 5 clear.
- R4: Register 3 bits 8:7 always equal `st_rate`, bit 6 always equals `st_pkg`, and bit 0 always equals `st_recok`. Host writes to these four bits have no effect. The other bits of register 3 are writable.
- R5: Opcode 64 with an address below 64 raises `mem_req` with `mem_we`=1, the address and the data word. The request is held until `mem_ack`. No report follows.
- R6: Opcode 80 with an address below 64 raises `mem_req` with `mem_we`=0. `cmd_ready` stays 0 until `mem_ack`. One report then follows, with flag bit 5 (memory source) set and the data taken from `mem_rdata`.
- R7: A one-cycle `mcu_wr` pulse produces one report with flag bit 6 (microcontroller source) set and the data equal to `mcu_data`.
- R8: Flag bit 0 is 1 while the debounced volume-up button is low. Flag bit 1 is 1 while the debounced volume-down button is low.
- R9: Flag bit 2 is set by a debounced press of the mute button. It stays set after release until a report handshake (`rpt_valid` and `rpt_ready` both 1) completes, and then clears.
- R10: Flag bit 3 equals the jack-sense input after a two-flop synchronizer. Flag bit 7 is always 0.
- R11: A button low pulse shorter than `DB_CNT` synchronized samples changes no flag.
- R12: While `rpt_valid` is 1 and `rpt_ready` is 0, the report stays offered and its data bytes stay stable.
- R13: A command with an unknown opcode, or with an address out of range for its target, is accepted and has no effect: no register changes, no memory request, no report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command bytes are valid |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 8 | Command byte 0: opcode |
| cmd_lo | input | 8 | Command byte 1: data low byte |
| cmd_hi | input | 8 | Command byte 2: data high byte |
| cmd_addr | input | 8 | Command byte 3: address |
| btn_volup_n | input | 1 | Volume-up button, active low |
| btn_voldn_n | input | 1 | Volume-down button, active low |
| btn_mute_n | input | 1 | Playback-mute button, active low |
| jack_sense | input | 1 | Headphone jack sense, active high |
| st_rate | input | 2 | Read-only status for register 3 bits 8:7 |
| st_pkg | input | 1 | Read-only status for register 3 bit 6 |
| st_recok | input | 1 | Read-only status for register 3 bit 0 |
| mcu_wr | input | 1 | Microcontroller word strobe |
| mcu_data | input | 16 | Microcontroller word |
| mem_req | output | 1 | Serial-memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | MEM_AW | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory request completed |
| mem_rdata | input | 16 | Memory read data, valid with `mem_ack` |
| reg0_o | output | 16 | Register 0 contents |
| reg1_o | output | 16 | Register 1 contents |
| reg2_o | output | 16 | Register 2 contents |
| reg3_o | output | 16 | Register 3 contents including status bits |
| rpt_valid | output | 1 | Status report offered |
| rpt_ready | input | 1 | Host takes the status report |
| rpt_flags | output | 8 | Report byte 0: flags |
| rpt_lo | output | 8 | Report byte 1: data low byte |
| rpt_hi | output | 8 | Report byte 2: data high byte |

## Verification
The bench builds the block with `DB_CNT` = 4 and the default `MEM_AW` = 6. The short debounce window makes both cases cheap to reach: a press that is accepted, and a two-cycle glitch that must be rejected. With the full 64-word address space, the boundary addresses 63 and 64 can both be exercised. The bench's memory responder answers after a randomly chosen delay of zero to several cycles. This covers the case where the acknowledge comes on the first waiting cycle, and it also holds the sequencer in its wait state long enough to observe `cmd_ready` held low.

// File: rtl/hrac_pkg.sv
package hrac_pkg;

    localparam logic [7:0] OP_REG_RD = 8'd48;
    localparam logic [7:0] OP_REG_WR = 8'd32;
    localparam logic [7:0] OP_MEM_RD = 8'd80;
    localparam logic [7:0] OP_MEM_WR = 8'd64;

    localparam int FLG_VUP  = 0;
    localparam int FLG_VDN  = 1;
    localparam int FLG_MUTE = 2;
    localparam int FLG_JACK = 3;
    localparam int FLG_REG  = 4;
    localparam int FLG_MEM  = 5;
    localparam int FLG_MCU  = 6;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_REG  = 2'd1,
        SRC_MEM  = 2'd2,
        SRC_MCU  = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_MEM_WAIT = 2'd1,
        ST_SEND     = 2'd2
    } state_e;

endpackage

// File: rtl/hrac_debounce.sv
module hrac_debounce #(
    parameter int COUNT     = 16,
    parameter bit RST_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level
);
    localparam int CW = $clog2(COUNT + 1);

    logic          sync_a;
    logic          sync_b;
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_a  <= RST_LEVEL;
            sync_b  <= RST_LEVEL;
            level   <= RST_LEVEL;
            run_cnt <= '0;
        end else begin
            sync_a <= raw;
            sync_b <= sync_a;
            if (sync_b == level) begin
                run_cnt <= '0;
            end else if (run_cnt == CW'(COUNT - 1)) begin
                level   <= sync_b;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    // level may only move after a full run of differing samples
    assert_db_settle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level) |-> ($past(run_cnt) == CW'(COUNT - 1)));

endmodule

// File: rtl/hrac_regfile.sv
module hrac_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 4,
    parameter int AW   = $clog2(NREG),
    parameter logic [NREG*DW-1:0] RST_VALS = '0,
    parameter logic [NREG*DW-1:0] WR_MASKS = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic [NREG*DW-1:0] ro_bits,
    input  logic [AW-1:0]      rd_addr,
    output logic [DW-1:0]      rd_data,
    output logic [NREG*DW-1:0] regs_o
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [DW-1:0] MASK = WR_MASKS[i*DW +: DW];
        logic [DW-1:0] store;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                store <= RST_VALS[i*DW +: DW] & MASK;
            end else if (wr_en && wr_addr == AW'(i)) begin
                store <= wr_data & MASK;
            end
        end

        assign regs_o[i*DW +: DW] = store | (ro_bits[i*DW +: DW] & ~MASK);

        assert_wr_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == AW'(i)) |=>
            ((regs_o[i*DW +: DW] & MASK) == ($past(wr_data) & MASK)));
    end

    assign rd_data = regs_o[rd_addr*DW +: DW];

endmodule

// File: rtl/hrac_status.sv
module hrac_status
    import hrac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       up_n,
    input  logic       dn_n,
    input  logic       mute_n,
    input  logic       jack_raw,
    input  src_e       src,
    input  logic       clr,
    output logic [7:0] flags
);
    logic jack_a;
    logic jack_b;
    logic mute_q;
    logic mute_sticky;
    logic mute_press;

    assign mute_press = mute_q && !mute_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            jack_a      <= 1'b0;
            jack_b      <= 1'b0;
            mute_q      <= 1'b1;
            mute_sticky <= 1'b0;
        end else begin
            jack_a <= jack_raw;
            jack_b <= jack_a;
            mute_q <= mute_n;
            if (mute_press) begin
                mute_sticky <= 1'b1;
            end else if (clr) begin
                mute_sticky <= 1'b0;
            end
        end
    end

    always_comb begin
        flags           = '0;
        flags[FLG_VUP]  = !up_n;
        flags[FLG_VDN]  = !dn_n;
        flags[FLG_MUTE] = mute_sticky;
        flags[FLG_JACK] = jack_b;
        flags[FLG_REG]  = (src == SRC_REG);
        flags[FLG_MEM]  = (src == SRC_MEM);
        flags[FLG_MCU]  = (src == SRC_MCU);
    end

    assert_mute_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mute_press |=> flags[FLG_MUTE]);

    assert_mute_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FLG_MUTE] && !clr) |=> flags[FLG_MUTE]);

    assert_one_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flags[FLG_MCU:FLG_REG]));

endmodule

// File: rtl/host_report_regacc.sv
module host_report_regacc
    import hrac_pkg::*;
#(
    parameter int DB_CNT = 16,
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [7:0]        cmd_op,
    input  logic [7:0]        cmd_lo,
    input  logic [7:0]        cmd_hi,
    input  logic [7:0]        cmd_addr,
    input  logic              btn_volup_n,
    input  logic              btn_voldn_n,
    input  logic              btn_mute_n,
    input  logic              jack_sense,
    input  logic [1:0]        st_rate,
    input  logic              st_pkg,
    input  logic              st_recok,
    input  logic              mcu_wr,
    input  logic [15:0]       mcu_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [15:0]       mem_rdata,
    output logic [15:0]       reg0_o,
    output logic [15:0]       reg1_o,
    output logic [15:0]       reg2_o,
    output logic [15:0]       reg3_o,
    output logic              rpt_valid,
    input  logic              rpt_ready,
    output logic [7:0]        rpt_flags,
    output logic [7:0]        rpt_lo,
    output logic [7:0]        rpt_hi
);
    localparam int DW        = 16;
    localparam int NREG      = 4;
    localparam int RAW       = $clog2(NREG);
    localparam int MEM_WORDS = 1 << MEM_AW;
    localparam int NBTN      = 3;
    localparam logic [NREG*DW-1:0] RST_VALS = {16'h003E, 16'h0004, 16'hB000, 16'h0000};
    localparam logic [NREG*DW-1:0] WR_MASKS = {16'hFE3E, {3{16'hFFFF}}};

    // debounced buttons
    logic [NBTN-1:0] btn_raw_n;
    logic [NBTN-1:0] btn_lvl_n;
    assign btn_raw_n = {btn_mute_n, btn_voldn_n, btn_volup_n};

    for (genvar g = 0; g < NBTN; g++) begin : g_db
        hrac_debounce #(.COUNT(DB_CNT), .RST_LEVEL(1'b1)) u_db (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (btn_raw_n[g]),
            .level (btn_lvl_n[g])
        );
    end

    // command decode
    state_e            st, st_nx;
    src_e              src_q;
    logic [DW-1:0]     data_q;
    logic              we_q;
    logic [MEM_AW-1:0] maddr_q;
    logic [DW-1:0]     mwdata_q;
    logic              mcu_pend;
    logic [DW-1:0]     mcu_word;

    logic cmd_fire, reg_hit, mem_hit, is_reg_rd, is_reg_wr, is_mem;
    logic [DW-1:0] reg_rd;
    logic [NREG*DW-1:0] regs_flat;
    logic [DW-1:0] ro_word;

    assign cmd_ready = (st == ST_IDLE) && !mcu_pend;
    assign cmd_fire  = cmd_valid && cmd_ready;
    assign reg_hit   = 32'(cmd_addr) < NREG;
    assign mem_hit   = 32'(cmd_addr) < MEM_WORDS;
    assign is_reg_rd = (cmd_op == OP_REG_RD) && reg_hit;
    assign is_reg_wr = (cmd_op == OP_REG_WR) && reg_hit;
    assign is_mem    = ((cmd_op == OP_MEM_RD) || (cmd_op == OP_MEM_WR)) && mem_hit;

    // register bank
    assign ro_word = {7'b0, st_rate, st_pkg, 5'b0, st_recok};

    hrac_regfile #(
        .DW       (DW),
        .NREG     (NREG),
        .AW       (RAW),
        .RST_VALS (RST_VALS),
        .WR_MASKS (WR_MASKS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cmd_fire && is_reg_wr),
        .wr_addr (cmd_addr[RAW-1:0]),
        .wr_data ({cmd_hi, cmd_lo}),
        .ro_bits ({ro_word, {(NREG-1)*DW{1'b0}}}),
        .rd_addr (cmd_addr[RAW-1:0]),
        .rd_data (reg_rd),
        .regs_o  (regs_flat)
    );

    assign reg0_o = regs_flat[0*DW +: DW];
    assign reg1_o = regs_flat[1*DW +: DW];
    assign reg2_o = regs_flat[2*DW +: DW];
    assign reg3_o = regs_flat[3*DW +: DW];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (mcu_pend)                    st_nx = ST_SEND;
                else if (cmd_fire && is_reg_rd)  st_nx = ST_SEND;
                else if (cmd_fire && is_mem)     st_nx = ST_MEM_WAIT;
            end
            ST_MEM_WAIT: begin
                if (mem_ack) st_nx = we_q ? ST_IDLE : ST_SEND;
            end
            ST_SEND: begin
                if (rpt_ready) st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // output and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q    <= SRC_NONE;
            data_q   <= '0;
            we_q     <= 1'b0;
            maddr_q  <= '0;
            mwdata_q <= '0;
            mcu_pend <= 1'b0;
            mcu_word <= '0;
        end else begin
            if (st == ST_IDLE && mcu_pend) begin
                src_q    <= SRC_MCU;
                data_q   <= mcu_word;
                mcu_pend <= 1'b0;
            end else if (cmd_fire && is_reg_rd) begin
                src_q  <= SRC_REG;
                data_q <= reg_rd;
            end else if (cmd_fire && is_mem) begin
                we_q     <= (cmd_op == OP_MEM_WR);
                maddr_q  <= cmd_addr[MEM_AW-1:0];
                mwdata_q <= {cmd_hi, cmd_lo};
            end
            if (st == ST_MEM_WAIT && mem_ack && !we_q) begin
                src_q  <= SRC_MEM;
                data_q <= mem_rdata;
            end
            if (mcu_wr) begin
                mcu_pend <= 1'b1;
                mcu_word <= mcu_data;
            end
        end
    end

    assign mem_req   = (st == ST_MEM_WAIT);
    assign mem_we    = we_q;
    assign mem_addr  = maddr_q;
    assign mem_wdata = mwdata_q;
    assign rpt_valid = (st == ST_SEND);
    assign rpt_lo    = data_q[7:0];
    assign rpt_hi    = data_q[15:8];

    hrac_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_n     (btn_lvl_n[0]),
        .dn_n     (btn_lvl_n[1]),
        .mute_n   (btn_lvl_n[2]),
        .jack_raw (jack_sense),
        .src      (rpt_valid ? src_q : SRC_NONE),
        .clr      (rpt_valid && rpt_ready),
        .flags    (rpt_flags)
    );

    assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_busy_holdoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cmd_ready);

    assert_rpt_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && !rpt_ready) |=> (rpt_valid && $stable(rpt_lo) && $stable(rpt_hi)));

    assert_write_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && cmd_op == OP_REG_WR) |=> !rpt_valid);

endmodule

// File: tb/host_report_regacc_tb_top.sv
`timescale 1ns/1ps
module host_report_regacc_tb_top;

    localparam int DB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [7:0]  cmd_op = '0, cmd_lo = '0, cmd_hi = '0, cmd_addr = '0;
    logic        btn_volup_n = 1'b1, btn_voldn_n = 1'b1, btn_mute_n = 1'b1;
    logic        jack_sense = 1'b0;
    logic [1:0]  st_rate = 2'b10;
    logic        st_pkg = 1'b1, st_recok = 1'b1;
    logic        mcu_wr = 1'b0;
    logic [15:0] mcu_data = '0;
    logic        mem_req, mem_we;
    logic [5:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic [15:0] reg0_o, reg1_o, reg2_o, reg3_o;
    logic        rpt_valid;
    logic        rpt_ready = 1'b0;
    logic [7:0]  rpt_flags, rpt_lo, rpt_hi;

    always #2.5 clk = ~clk;

    host_report_regacc #(.DB_CNT(DB), .MEM_AW(6)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_lo(cmd_lo), .cmd_hi(cmd_hi), .cmd_addr(cmd_addr),
        .btn_volup_n(btn_volup_n), .btn_voldn_n(btn_voldn_n), .btn_mute_n(btn_mute_n),
        .jack_sense(jack_sense), .st_rate(st_rate), .st_pkg(st_pkg), .st_recok(st_recok),
        .mcu_wr(mcu_wr), .mcu_data(mcu_data), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .reg0_o(reg0_o), .reg1_o(reg1_o), .reg2_o(reg2_o), .reg3_o(reg3_o),
        .rpt_valid(rpt_valid), .rpt_ready(rpt_ready), .rpt_flags(rpt_flags),
        .rpt_lo(rpt_lo), .rpt_hi(rpt_hi)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [15:0] model_reg [4];
    logic [15:0] exp_mem   [64];
    logic [15:0] resp_mem  [64];
    int          mem_lat = 0;
    logic        exp_we;
    logic [5:0]  exp_maddr;
    logic [15:0] exp_mwd;

    localparam int S_REG = 1, S_MEM = 2, S_MCU = 3;

    function automatic logic [7:0] exp_flags(int src, bit jk, bit mt, bit dn, bit up);
        return {1'b0, src == S_MCU, src == S_MEM, src == S_REG, jk, mt, dn, up};
    endfunction

    function automatic logic [15:0] exp_reg(int a);
        if (a == 3)
            return (model_reg[3] & 16'hFE3E) | {7'b0, st_rate, st_pkg, 5'b0, st_recok};
        return model_reg[a];
    endfunction

    function automatic logic [15:0] reg_out(int a);
        case (a)
            0: return reg0_o;
            1: return reg1_o;
            2: return reg2_o;
            default: return reg3_o;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    task automatic send_cmd(logic [7:0] op, logic [7:0] a, logic [15:0] d);
        exp_we    = (op == 8'd64);
        exp_maddr = a[5:0];
        exp_mwd   = d;
        @(negedge clk);
        cmd_op = op; cmd_addr = a; cmd_lo = d[7:0]; cmd_hi = d[15:8]; cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        #1 cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int k = 0;
        @(negedge clk);
        while (!cmd_ready && k < 100) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic expect_quiet(string req, int n);
        repeat (n) begin
            @(negedge clk);
            chk(req, {31'b0, rpt_valid}, 32'd0);
        end
    endtask

    task automatic get_rpt(string req, int src, logic [15:0] d, bit jk, bit mt, bit dn, bit up);
        int k = 0;
        @(negedge clk);
        while (!rpt_valid && k < 200) begin
            @(negedge clk);
            k++;
        end
        chk({req, " report offered"}, {31'b0, rpt_valid}, 32'd1);
        chk({req, " flags"}, {24'b0, rpt_flags}, {24'b0, exp_flags(src, jk, mt, dn, up)});
        chk({req, " data"}, {16'b0, rpt_hi, rpt_lo}, {16'b0, d});
        rpt_ready = 1'b1;
        @(posedge clk);
        #1 rpt_ready = 1'b0;
    endtask

    task automatic mcu_push(logic [15:0] w);
        @(negedge clk);
        mcu_wr = 1'b1; mcu_data = w;
        @(negedge clk);
        mcu_wr = 1'b0;
    endtask

    // serial memory responder with programmable latency
    initial begin
        int lat_cnt = 0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req) begin
                if (lat_cnt >= mem_lat) begin
                    chk("R5 request kind", {31'b0, mem_we}, {31'b0, exp_we});
                    chk("R5 request address", {26'b0, mem_addr}, {26'b0, exp_maddr});
                    if (mem_we) begin
                        chk("R5 write data", {16'b0, mem_wdata}, {16'b0, exp_mwd});
                        resp_mem[mem_addr] = mem_wdata;
                    end else begin
                        mem_rdata = resp_mem[mem_addr];
                    end
                    mem_ack = 1'b1;
                    lat_cnt = 0;
                end else begin
                    lat_cnt++;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not complete");
        finish_up();
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reg[0] = 16'h0000; model_reg[1] = 16'hB000;
        model_reg[2] = 16'h0004; model_reg[3] = 16'h003E;
        for (int i = 0; i < 64; i++) begin
            exp_mem[i]  = 16'(i * 16'h0101) ^ 16'h5A5A;
            resp_mem[i] = exp_mem[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) chk("R1 reset value", {16'b0, reg_out(a)}, {16'b0, exp_reg(a)});
        chk("R1 no report", {31'b0, rpt_valid}, 32'd0);
        chk("R1 no request", {31'b0, mem_req}, 32'd0);
        chk("R1 ready", {31'b0, cmd_ready}, 32'd1);

        // R2 register write, silent
        send_cmd(8'd32, 8'd0, 16'h1234);
        model_reg[0] = 16'h1234;
        chk("R2 write lands", {16'b0, reg0_o}, 32'h1234);
        expect_quiet("R2 no report after write", 5);

        // R3 register read
        send_cmd(8'd48, 8'd1, 16'h0000);
        get_rpt("R3", S_REG, exp_reg(1), 0, 0, 0, 0);
        expect_quiet("R3 exactly one report", 3);

        // R4 read-only bits of register 3
        send_cmd(8'd32, 8'd3, 16'hFFFF);
        model_reg[3] = 16'hFFFF;
        @(negedge clk);
        chk("R4 ro bits ignore write", {16'b0, reg3_o}, {16'b0, exp_reg(3)});
        send_cmd(8'd32, 8'd3, 16'h0000);
        model_reg[3] = 16'h0000;
        st_rate = 2'b01; st_pkg = 1'b0; st_recok = 1'b1;
        @(negedge clk);
        chk("R4 ro bits follow status", {16'b0, reg3_o}, {16'b0, exp_reg(3)});
        send_cmd(8'd48, 8'd3, 16'h0000);
        get_rpt("R4 readback", S_REG, exp_reg(3), 0, 0, 0, 0);

        // R13 unknown opcode and out-of-range addresses
        send_cmd(8'd99, 8'd0, 16'hFFFF);
        send_cmd(8'd32, 8'd7, 16'hFFFF);
        @(negedge clk);
        chk("R13 register unchanged", {16'b0, reg0_o}, 32'h1234);
        send_cmd(8'd48, 8'd5, 16'h0000);
        send_cmd(8'd80, 8'd64, 16'h0000);
        @(negedge clk);
        chk("R13 no request", {31'b0, mem_req}, 32'd0);
        expect_quiet("R13 no report", 4);

        // R5 and R6 memory write with slow acknowledge, then read back
        mem_lat = 5;
        send_cmd(8'd64, 8'd63, 16'hBEEF);
        exp_mem[63] = 16'hBEEF;
        @(negedge clk);
        chk("R6 ready low while pending", {31'b0, cmd_ready}, 32'd0);
        chk("R5 request raised", {31'b0, mem_req}, 32'd1);
        wait_idle();
        expect_quiet("R5 no report after write", 3);
        mem_lat = 3;
        send_cmd(8'd80, 8'd63, 16'h0000);
        @(negedge clk);
        chk("R6 ready low during read", {31'b0, cmd_ready}, 32'd0);
        get_rpt("R6", S_MEM, exp_mem[63], 0, 0, 0, 0);
        mem_lat = 0;
        send_cmd(8'd80, 8'd0, 16'h0000);
        get_rpt("R6 zero latency", S_MEM, exp_mem[0], 0, 0, 0, 0);

        // R7 and R12 microcontroller word, held report
        mcu_push(16'hA55A);
        repeat (3) @(negedge clk);
        chk("R12 still offered", {31'b0, rpt_valid}, 32'd1);
        chk("R12 data held", {16'b0, rpt_hi, rpt_lo}, 32'hA55A);
        get_rpt("R7", S_MCU, 16'hA55A, 0, 0, 0, 0);

        // R10 jack sense
        jack_sense = 1'b1;
        repeat (3) @(negedge clk);
        mcu_push(16'h0001);
        get_rpt("R10", S_MCU, 16'h0001, 1, 0, 0, 0);
        jack_sense = 1'b0;
        repeat (3) @(negedge clk);

        // R8 volume buttons held
        btn_volup_n = 1'b0; btn_voldn_n = 1'b0;
        repeat (DB + 6) @(negedge clk);
        mcu_push(16'h0002);
        get_rpt("R8 pressed", S_MCU, 16'h0002, 0, 0, 1, 1);
        btn_volup_n = 1'b1;
        repeat (DB + 6) @(negedge clk);
        mcu_push(16'h0003);
        get_rpt("R8 up released", S_MCU, 16'h0003, 0, 0, 1, 0);
        btn_voldn_n = 1'b1;
        repeat (DB + 6) @(negedge clk);

        // R11 short glitches rejected
        btn_volup_n = 1'b0; btn_mute_n = 1'b0;
        repeat (2) @(negedge clk);
        btn_volup_n = 1'b1; btn_mute_n = 1'b1;
        repeat (DB + 6) @(negedge clk);
        mcu_push(16'h0004);
        get_rpt("R11 glitch", S_MCU, 16'h0004, 0, 0, 0, 0);

        // R9 sticky mute
        btn_mute_n = 1'b0;
        repeat (DB + 6) @(negedge clk);
        btn_mute_n = 1'b1;
        repeat (DB + 6) @(negedge clk);
        mcu_push(16'h0005);
        get_rpt("R9 set after release", S_MCU, 16'h0005, 0, 1, 0, 0);
        mcu_push(16'h0006);
        get_rpt("R9 cleared by read", S_MCU, 16'h0006, 0, 0, 0, 0);

        // constrained random mix checked against the bench model
        for (int it = 0; it < 200; it++) begin
            int kind = int'($urandom % 4);
            logic [15:0] d = 16'($urandom);
            jack_sense = 1'($urandom);
            repeat (3) @(negedge clk);
            mem_lat = int'($urandom % 4);
            case (kind)
                0: begin
                    int a = int'($urandom % 4);
                    send_cmd(8'd32, 8'(a), d);
                    model_reg[a] = d;
                    @(negedge clk);
                    chk("R2 random write", {16'b0, reg_out(a)}, {16'b0, exp_reg(a)});
                end
                1: begin
                    int a = int'($urandom % 4);
                    send_cmd(8'd48, 8'(a), 16'h0000);
                    get_rpt("R3 random read", S_REG, exp_reg(a), jack_sense, 0, 0, 0);
                end
                2: begin
                    int a = int'($urandom % 64);
                    send_cmd(8'd64, 8'(a), d);
                    exp_mem[a] = d;
                    wait_idle();
                end
                default: begin
                    int a = int'($urandom % 64);
                    send_cmd(8'd80, 8'(a), 16'h0000);
                    get_rpt("R6 random read", S_MEM, exp_mem[a], jack_sense, 0, 0, 0);
                end
            endcase
        end

        repeat (5) @(negedge clk);
        finish_up();
    end

endmodule